// File: doc/BRIEF.md
# Radix-2 SRT Sequential Divider

This block divides one unsigned W-bit number by another and returns the quotient and the remainder. It uses radix-2 SRT iteration. First it normalises the divisor so that its most significant bit is set. It then runs W iterations. In each one a signed digit from {-1, 0, +1} is chosen by looking only at the three highest bits of the shifted partial remainder. A digit of 0 costs nothing but a shift. A digit of +1 or -1 costs one pass through a single add/subtract unit.

The +1 and -1 digits are collected in two separate vectors. Subtracting the second vector from the first gives the binary quotient. One extra cycle makes the remainder non-negative, adjusts the quotient to match, and shifts the remainder right by the normalisation amount. A caller pulses `start` with both operands present, waits for the one-cycle `done` pulse, and then reads the results, which stay valid until the next accepted operation completes.

Top module: `srt_divider`

## Requirements
- R1: With a nonzero divisor Y and dividend X, both taken as unsigned W-bit values, the outputs after `done` are quotient = floor(X/Y) and remainder = X - quotient*Y.
- R2: On an accepted start the divisor is shifted left by its count k of leading zeros at W bits (0 <= k <= W-1). The stored normalised divisor then has bit W-1 set. Divisors with any number of leading zeros from 0 to W-1 give correct results.
- R3: Each iteration shifts the partial remainder and dividend left by one bit. If the top three bits of the shifted remainder are all equal, the digit is 0 and no arithmetic is done. If they are not all equal and the sign bit is 1, the digit is -1 and the divisor is added. Otherwise the digit is +1 and the divisor is subtracted.
- R4: Whenever a normalised divisor B is held, the signed partial remainder A satisfies -B < A < B.
- R5: After the last iteration, a negative partial remainder gets B added to it and the quotient is reduced by one. The remainder output is always less than the divisor.
- R6: `done` is high for exactly one cycle. It goes high after the (W+2)-th rising edge, counting the edge that samples `start`, and is low during the cycles before that.
- R7: `start` is ignored while an operation is in progress. Operands are sampled only at an accepted start, so later changes on `start`, `dividend` or `divisor` do not change that operation's result.
- R8: After reset `done`, `quotient` and `remainder` are all 0.
- R9: `quotient` and `remainder` keep their values after `done` until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when the divider is idle |
| dividend | input | W | Unsigned dividend, sampled at an accepted start |
| divisor | input | W | Unsigned nonzero divisor, sampled at an accepted start |
| quotient | output | W | Unsigned quotient |
| remainder | output | W | Unsigned remainder |
| done | output | 1 | One-cycle pulse when results are updated |

## Verification
The bench builds the divider with W = 8. At that width every normalisation shift from 0 to 7 comes up often under random divisors. The full quotient range, from 0 up to 255 with a divisor of 1, is also reachable. Random operands are biased towards small divisors so that long shift-only digit runs and negative final remainders that need correction appear often. Directed cases cover a divisor larger than the dividend, equal operands, extreme values, and a second start pulse while the divider is busy.

// File: rtl/srt_div_pkg.sv
package srt_div_pkg;

  // Strobes the sequencer hands to the datapath each cycle
  typedef struct packed {
    logic load;   // capture and normalise operands
    logic step;   // one digit-selection iteration
    logic fix;    // sign correction and denormalisation
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } ctrlState_t;

endpackage

// File: rtl/srt_lzc.sv
module srt_lzc #(
  parameter int W = 16,
  localparam int KW = $clog2(W + 1)
) (
  input  logic [W-1:0]  value,
  output logic [KW-1:0] count
);

  // Scan upward so the highest set bit writes last and wins
  always_comb begin
    count = KW'(W);
    for (int i = 0; i < W; i++) begin
      if (value[i]) count = KW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/srt_div_ctrl.sv
module srt_div_ctrl
  import srt_div_pkg::*;
#(
  parameter int W = 16,
  localparam int CW = (W > 2) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strb,
  output logic         done
);

  localparam logic [CW-1:0] LAST_ITER = CW'(W - 1);

  ctrlState_t     state;
  logic [CW-1:0]  iterCnt;

  always_comb begin
    strb      = '0;
    strb.load = (state == ST_IDLE) && start;
    strb.step = (state == ST_RUN);
    strb.fix  = (state == ST_FIX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state == ST_FIX);
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          iterCnt <= '0;
        end
        ST_RUN: begin
          iterCnt <= iterCnt + CW'(1);
          if (iterCnt == LAST_ITER) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: results announced for a single cycle only
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: done coincides with the return to idle
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (state == ST_IDLE));

  // R7: an accepted start always begins a fresh iteration count
  p_start_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start) |=> (state == ST_RUN && iterCnt == '0));

endmodule

// File: rtl/srt_div_dp.sv
module srt_div_dp
  import srt_div_pkg::*;
#(
  parameter int W = 16,
  localparam int AW = W + 2,
  localparam int KW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  logic [AW-1:0]  accReg;      // signed partial remainder
  logic [W-1:0]   dividendSh;  // dividend bits still to enter accReg
  logic [W-1:0]   divisorN;    // normalised divisor
  logic [W-1:0]   posDig;      // +1 digits
  logic [W-1:0]   negDig;      // -1 digits
  logic [KW-1:0]  shiftK;

  logic [KW-1:0]  lzCount;
  logic [2*W-1:0] wideDividend;
  logic [AW-1:0]  shiftedAcc;
  logic [AW-1:0]  bExt;
  logic [AW-1:0]  addend;
  logic [AW-1:0]  stepSum;
  logic [2:0]     top3;
  logic           digitZero;
  logic           isNeg;
  logic           needFix;
  logic [W-1:0]   rawQuot;
  logic [W-1:0]   remFixed;

  srt_lzc #(.W(W)) u_lzc (
    .value (divisor),
    .count (lzCount)
  );

  always_comb begin
    wideDividend = {{W{1'b0}}, dividend} << lzCount;
    bExt         = {2'b00, divisorN};
    shiftedAcc   = {accReg[AW-2:0], dividendSh[W-1]};
    top3         = shiftedAcc[AW-1 -: 3];
    digitZero    = (top3 == 3'b000) || (top3 == 3'b111);
    isNeg        = shiftedAcc[AW-1];
    // single adder: add B when negative, else add ~B + 1
    addend       = isNeg ? bExt : ~bExt;
    stepSum      = shiftedAcc + addend + {{(AW-1){1'b0}}, ~isNeg};
    needFix      = accReg[AW-1];
    rawQuot      = posDig - negDig;
    remFixed     = needFix ? (accReg[W-1:0] + divisorN) : accReg[W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg     <= '0;
      dividendSh <= '0;
      divisorN   <= '0;
      posDig     <= '0;
      negDig     <= '0;
      shiftK     <= '0;
      quotient   <= '0;
      remainder  <= '0;
    end else if (strb.load) begin
      accReg     <= {2'b00, wideDividend[2*W-1:W]};
      dividendSh <= wideDividend[W-1:0];
      divisorN   <= divisor << lzCount;
      shiftK     <= lzCount;
      posDig     <= '0;
      negDig     <= '0;
    end else if (strb.step) begin
      dividendSh <= {dividendSh[W-2:0], 1'b0};
      if (digitZero) begin
        accReg <= shiftedAcc;
        posDig <= {posDig[W-2:0], 1'b0};
        negDig <= {negDig[W-2:0], 1'b0};
      end else begin
        accReg <= stepSum;
        posDig <= {posDig[W-2:0], ~isNeg};
        negDig <= {negDig[W-2:0], isNeg};
      end
    end else if (strb.fix) begin
      accReg    <= {2'b00, remFixed};
      quotient  <= rawQuot - {{(W-1){1'b0}}, needFix};
      remainder <= remFixed >> shiftK;
    end
  end

  // R2: a held divisor is always normalised
  p_norm_msb_r2: assert property (@(posedge clk) disable iff (!rstN)
    (divisorN != '0) |-> divisorN[W-1]);

  // R4: partial remainder stays strictly inside (-B, B)
  p_partial_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (divisorN != '0) |-> (($signed(accReg) < $signed(bExt)) &&
                          ($signed(accReg) > -$signed(bExt))));

  // R5: corrected remainder is below the original divisor
  p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.fix |=> (remainder < (divisorN >> shiftK)));

endmodule

// File: rtl/srt_divider.sv
module srt_divider
  import srt_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done
);

  ctrlStrobes_t strb;

  srt_div_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .done  (done)
  );

  srt_div_dp #(.W(W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder)
  );

endmodule

// File: tb/srt_divider_bench.sv
`timescale 1ns/1ps
module srt_divider_bench;

  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;
  logic         done;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  srt_divider #(.W(W)) u_srt_divider (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .done      (done)
  );

  function automatic int refQuot(input int x, input int y);
    return x / y;
  endfunction

  function automatic int refRem(input int x, input int y);
    return x % y;
  endfunction

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One operation; optionally pulses start with other operands while busy
  task automatic runDivide(input int x, input int y, input string req, input bit midStart);
    bit earlyDone;
    earlyDone = 1'b0;
    dividend = W'(x);
    divisor  = W'(y);
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= W + 1; i++) begin
      if (midStart && i == 3) begin
        start    = 1'b1;
        dividend = W'(MAXV - x);
        divisor  = W'(3);
      end
      if (midStart && i == 4) start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (i <= W && done) earlyDone = 1'b1;
    end
    checkVal({req, " R6"}, "done early", int'(earlyDone), 0);
    checkVal({req, " R6"}, "done at W+2", int'(done), 1);
    checkVal({req, " R1 R3"}, $sformatf("quot %0d/%0d", x, y), int'(quotient), refQuot(x, y));
    checkVal({req, " R1 R4 R5"}, $sformatf("rem %0d%%%0d", x, y), int'(remainder), refRem(x, y));
    @(posedge clk);
    @(negedge clk);
    checkVal({req, " R6"}, "done falls", int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R8: reset state
    checkVal("R8", "done in reset", int'(done), 0);
    checkVal("R8", "quot in reset", int'(quotient), 0);
    checkVal("R8", "rem in reset", int'(remainder), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R8", "done after reset", int'(done), 0);

    // Directed corners
    runDivide(13, 5, "R1 R5", 1'b0);
    runDivide(MAXV, 1, "R2", 1'b0);          // k = W-1, largest quotient
    runDivide(0, 7, "R1", 1'b0);
    runDivide(7, 200, "R1", 1'b0);           // divisor above dividend
    runDivide(MAXV, MAXV, "R1", 1'b0);
    runDivide(128, 128, "R2", 1'b0);         // k = 0
    runDivide(1, MAXV, "R1", 1'b0);
    runDivide(MAXV, 2, "R2", 1'b0);
    runDivide(254, 127, "R2", 1'b0);
    runDivide(100, 3, "R5", 1'b0);

    // R7: start pulse while busy is ignored
    runDivide(200, 7, "R7", 1'b1);
    // R9: results held afterwards, inputs changed
    dividend = 8'd11;
    divisor  = 8'd2;
    repeat (5) @(negedge clk);
    checkVal("R9", "quot held", int'(quotient), 200 / 7);
    checkVal("R9", "rem held", int'(remainder), 200 % 7);

    // Every normalisation shift
    for (int k = 0; k < W; k++) begin
      int y;
      y = 1 << (W - 1 - k);
      runDivide(MAXV - k, y, "R2", 1'b0);
      runDivide(37 + k, y | 1, "R2", 1'b0);
    end

    // Constrained random, biased towards small divisors
    for (int n = 0; n < 300; n++) begin
      int x;
      int y;
      x = int'($urandom % (MAXV + 1));
      if ($urandom % 2 == 0) y = 1 + int'($urandom % 8);
      else y = 1 + int'($urandom % MAXV);
      runDivide(x, y, "R3", 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R6 watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule